// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the data side of a small multi-cycle processor. Every register transfer crosses one shared 32-bit bus. The block holds the general register array, the program counter, two operand latches, a memory address register, an instruction register, an immediate former and an ALU. In any cycle at most one source drives the bus, and any number of destinations may capture the bus value at the next clock edge.

An external sequencer supplies the control word for each cycle. The word carries a register selector, load strobes, source enables, an immediate selector and an ALU operation. The block returns the current opcode, an operand-equality flag and the busy flag of the memory. The memory is reached through an address, a bus-sourced write-data path, a request, a write flag and a busy input. The program counter has no port of its own. It is entry 32 of the register array and is read and written through the same selector as the general registers.

Top module: `sbus_datapath`

## Requirements
- R1: While reset is held low, and after it is released, the operand latches, the address register, the instruction register and general entries 1..31 hold zero, and the PC entry holds `RESET_PC`.
- R2: The bus carries the value of the single enabled source. With no source enabled it carries zero. At most one of `reg_en`, `alu_en`, `imm_en` and the memory read drive is active in a cycle. `mem_wdata` shows the bus.
- R3: The operand latches A and B, the address register and the instruction register each capture the bus at a rising edge when their own load strobe is high, and hold their value otherwise. `mem_addr` shows the address register.
- R4: The register selector `reg_sel` is decoded as follows: 0 = rs1 field IR[26:22], 1 = rs2 field IR[21:17], 2 = rd field IR[31:27], 3 = PC (entry 32), 4 = link register (entry 1).
- R5: With `reg_wr` high, the selected entry takes the bus value at the rising edge. A write to entry 0 is dropped, and entry 0 always reads zero.
- R6: The `alu_op` codes are: 0 A+B, 1 A−B, 2 A, 3 A&B, 4 A|B, 5 A^B, 6 A+4, 7 A + (sign-extended B[31:7] shifted left by one).
- R7: The `imm_sel` codes are: 0 sign-extended IR[21:10]; 1 sign-extended {IR[31:27],IR[16:10]} shifted left by one; 2 IR[26:7] placed above twelve zero bits; 3 the whole IR.
- R8: `br_eq` is high exactly when latch A equals latch B.
- R9: `opcode` shows IR[6:0].
- R10: `mem_req` follows `mem_en`, and `mem_we` is `mem_en & mem_wr`. The memory drives the bus with `mem_rdata` only when `mem_en` is high and `mem_wr` is low. `busy` follows `mem_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| reg_sel | input | 3 | Register index source (R4 encoding) |
| reg_wr | input | 1 | Write bus into selected entry |
| reg_en | input | 1 | Selected entry drives the bus |
| ld_a | input | 1 | Capture bus into latch A |
| ld_b | input | 1 | Capture bus into latch B |
| ld_ma | input | 1 | Capture bus into the address register |
| ld_ir | input | 1 | Capture bus into the instruction register |
| alu_op | input | 3 | ALU operation (R6 encoding) |
| alu_en | input | 1 | ALU result drives the bus |
| imm_sel | input | 2 | Immediate form (R7 encoding) |
| imm_en | input | 1 | Immediate drives the bus |
| mem_en | input | 1 | Memory access this cycle |
| mem_wr | input | 1 | 1 = write, 0 = read |
| opcode | output | 7 | IR[6:0] |
| br_eq | output | 1 | A equals B |
| busy | output | 1 | Memory busy, passed through |
| mem_addr | output | 32 | Address register contents |
| mem_wdata | output | 32 | Bus value offered for writes |
| mem_rdata | input | 32 | Read data from memory |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_busy | input | 1 | Memory still working |

## Verification
The hardest state to reach from the ports is a register-file entry selected through an IR field. The index comes from an instruction that must first be fetched over the bus from the memory data input. Only after that can a value land in the entry, and the entry is observed again only through another selected read. The stimulus loads crafted instruction words for the directed cases, including one whose rd field is zero. A long run then loads random words into IR through the memory path, so that reads and writes scatter across all 33 entries. A behavioural model predicts the bus on every cycle.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

   typedef enum logic [2:0] {
      SEL_RS1  = 3'd0,
      SEL_RS2  = 3'd1,
      SEL_RD   = 3'd2,
      SEL_PC   = 3'd3,
      SEL_LINK = 3'd4
   } regsel_e;

   typedef enum logic [2:0] {
      ALU_ADD   = 3'd0,
      ALU_SUB   = 3'd1,
      ALU_PASSA = 3'd2,
      ALU_AND   = 3'd3,
      ALU_OR    = 3'd4,
      ALU_XOR   = 3'd5,
      ALU_INC4  = 3'd6,
      ALU_JUMP  = 3'd7
   } aluop_e;

   typedef enum logic [1:0] {
      IMM_I  = 2'd0,
      IMM_BR = 2'd1,
      IMM_UP = 2'd2,
      IMM_IR = 2'd3
   } immsel_e;

   localparam int IR_W    = 32;
   localparam int FLD_W   = 5;
   localparam int RD_LSB  = 27;
   localparam int RS1_LSB = 22;
   localparam int RS2_LSB = 17;
   localparam int OPC_W   = 7;
   localparam int LINK_IX = 1;

endpackage

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
   parameter int               XLEN     = 32,
   parameter int               NGPR     = 32,
   parameter logic [XLEN-1:0]  RESET_PC = '0,
   parameter int               IDXW     = $clog2(NGPR + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [IDXW-1:0] idx,
   input  logic            we,
   input  logic [XLEN-1:0] wdata,
   output logic [XLEN-1:0] rdata
);
   localparam int NENT = NGPR + 1;

   logic [XLEN-1:0] ent [NENT];

   for (genvar g = 0; g < NENT; g++) begin : g_ent
      if (g == 0) begin : g_zero
         assign ent[g] = '0;
      end else begin : g_flop
         localparam logic [XLEN-1:0] RVAL = (g == NGPR) ? RESET_PC : '0;
         logic [XLEN-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= RVAL;
            else if (we && (idx == IDXW'(g)))
               q <= wdata;
         end
         assign ent[g] = q;
      end
   end

   always_comb begin
      rdata = '0;
      if (int'(idx) < NENT)
         rdata = ent[idx];
   end

   // R5: a write to a real entry is visible in that entry one cycle later
   a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (we && idx != '0 && int'(idx) < NENT) |=> (ent[$past(idx)] == $past(wdata)));

endmodule

// File: rtl/sbus_immgen.sv
module sbus_immgen
   import sbus_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [IR_W-1:0] ir,
   input  immsel_e         sel,
   output logic [XLEN-1:0] imm
);
   logic [11:0] br_off;
   assign br_off = {ir[31:27], ir[16:10]};

   always_comb begin
      unique case (sel)
         IMM_I:   imm = XLEN'($signed(ir[21:10]));
         IMM_BR:  imm = XLEN'($signed({br_off, 1'b0}));
         IMM_UP:  imm = XLEN'($signed({ir[26:7], 12'h000}));
         default: imm = XLEN'(ir);
      endcase
   end

endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
   import sbus_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  aluop_e          op,
   output logic [XLEN-1:0] y
);
   logic [XLEN-1:0] jump_off;
   assign jump_off = XLEN'($signed({b[31:7], 1'b0}));

   always_comb begin
      unique case (op)
         ALU_ADD:   y = a + b;
         ALU_SUB:   y = a - b;
         ALU_PASSA: y = a;
         ALU_AND:   y = a & b;
         ALU_OR:    y = a | b;
         ALU_XOR:   y = a ^ b;
         ALU_INC4:  y = a + XLEN'(4);
         default:   y = a + jump_off;
      endcase
   end

endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
   import sbus_pkg::*;
#(
   parameter int              XLEN     = 32,
   parameter int              NGPR     = 32,
   parameter logic [XLEN-1:0] RESET_PC = 'h200
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       reg_sel,
   input  logic             reg_wr,
   input  logic             reg_en,
   input  logic             ld_a,
   input  logic             ld_b,
   input  logic             ld_ma,
   input  logic             ld_ir,
   input  logic [2:0]       alu_op,
   input  logic             alu_en,
   input  logic [1:0]       imm_sel,
   input  logic             imm_en,
   input  logic             mem_en,
   input  logic             mem_wr,
   output logic [OPC_W-1:0] opcode,
   output logic             br_eq,
   output logic             busy,
   output logic [XLEN-1:0]  mem_addr,
   output logic [XLEN-1:0]  mem_wdata,
   input  logic [XLEN-1:0]  mem_rdata,
   output logic             mem_req,
   output logic             mem_we,
   input  logic             mem_busy
);
   localparam int IDXW = $clog2(NGPR + 1);

   if (XLEN < IR_W) begin : g_bad_xlen
      $error("XLEN must be at least the instruction width");
   end
   if (NGPR != (1 << FLD_W)) begin : g_bad_ngpr
      $error("NGPR must match the register field width");
   end

   logic [XLEN-1:0] bus, rf_rd, alu_y, imm_v;
   logic [XLEN-1:0] a_q, b_q, ma_q;
   logic [IR_W-1:0] ir_q;
   logic [IDXW-1:0] rf_idx;
   logic            mem_drive;

   always_comb begin
      unique case (regsel_e'(reg_sel))
         SEL_RS1:  rf_idx = IDXW'(ir_q[RS1_LSB +: FLD_W]);
         SEL_RS2:  rf_idx = IDXW'(ir_q[RS2_LSB +: FLD_W]);
         SEL_RD:   rf_idx = IDXW'(ir_q[RD_LSB +: FLD_W]);
         SEL_PC:   rf_idx = IDXW'(NGPR);
         SEL_LINK: rf_idx = IDXW'(LINK_IX);
         default:  rf_idx = '0;
      endcase
   end

   sbus_regfile #(.XLEN(XLEN), .NGPR(NGPR), .RESET_PC(RESET_PC), .IDXW(IDXW)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .idx   (rf_idx),
      .we    (reg_wr),
      .wdata (bus),
      .rdata (rf_rd)
   );

   sbus_alu #(.XLEN(XLEN)) u_alu (
      .a  (a_q),
      .b  (b_q),
      .op (aluop_e'(alu_op)),
      .y  (alu_y)
   );

   sbus_immgen #(.XLEN(XLEN)) u_imm (
      .ir  (ir_q),
      .sel (immsel_e'(imm_sel)),
      .imm (imm_v)
   );

   assign mem_drive = mem_en & ~mem_wr;

   assign bus = ({XLEN{reg_en}}    & rf_rd)
              | ({XLEN{mem_drive}} & mem_rdata)
              | ({XLEN{alu_en}}    & alu_y)
              | ({XLEN{imm_en}}    & imm_v);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q  <= '0;
         b_q  <= '0;
         ma_q <= '0;
         ir_q <= '0;
      end else begin
         if (ld_a)  a_q  <= bus;
         if (ld_b)  b_q  <= bus;
         if (ld_ma) ma_q <= bus;
         if (ld_ir) ir_q <= bus[IR_W-1:0];
      end
   end

   assign opcode    = ir_q[OPC_W-1:0];
   assign br_eq     = (a_q == b_q);
   assign busy      = mem_busy;
   assign mem_addr  = ma_q;
   assign mem_wdata = bus;
   assign mem_req   = mem_en;
   assign mem_we    = mem_en & mem_wr;

   // R2: never more than one bus source
   a_r2_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({reg_en, mem_drive, alu_en, imm_en}) <= 1);

   // R3: latch A and IR hold what the bus carried at the load edge
   a_r3_a_capture: assert property (@(posedge clk) disable iff (!rst_n)
      ld_a |=> (a_q == $past(bus)));

   a_r3_ir_capture: assert property (@(posedge clk) disable iff (!rst_n)
      ld_ir |=> (ir_q == $past(bus[IR_W-1:0])));

   // R3: address register is stable without its load strobe
   a_r3_ma_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_ma |=> $stable(ma_q));

   // R5: reading entry 0 as the only source leaves the bus at zero
   a_r5_x0_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_en && rf_idx == '0 && !mem_drive && !alu_en && !imm_en) |-> (bus == '0));

endmodule

// File: tb/tb_sbus_datapath.sv
module tb_sbus_datapath;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  reg_sel = '0;
   logic        reg_wr = 0, reg_en = 0, ld_a = 0, ld_b = 0, ld_ma = 0, ld_ir = 0;
   logic [2:0]  alu_op = '0;
   logic        alu_en = 0;
   logic [1:0]  imm_sel = '0;
   logic        imm_en = 0, mem_en = 0, mem_wr = 0, mem_busy = 0;
   logic [31:0] mem_rdata = '0;
   logic [6:0]  opcode;
   logic        br_eq, busy, mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   sbus_datapath dut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_en(reg_en),
      .ld_a(ld_a), .ld_b(ld_b), .ld_ma(ld_ma), .ld_ir(ld_ir), .alu_op(alu_op),
      .alu_en(alu_en), .imm_sel(imm_sel), .imm_en(imm_en), .mem_en(mem_en),
      .mem_wr(mem_wr), .opcode(opcode), .br_eq(br_eq), .busy(busy),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_busy(mem_busy)
   );

   // reference state
   logic [31:0] m_reg [33];
   logic [31:0] m_a, m_b, m_ma, m_ir;

   function automatic int m_idx(input logic [2:0] s, input logic [31:0] ir);
      case (s)
         3'd0: return int'(ir[26:22]);
         3'd1: return int'(ir[21:17]);
         3'd2: return int'(ir[31:27]);
         3'd3: return 32;
         3'd4: return 1;
         default: return 0;
      endcase
   endfunction

   function automatic logic [31:0] m_imm(input logic [1:0] s, input logic [31:0] ir);
      logic [31:0] v;
      case (s)
         2'd0: v = {{20{ir[21]}}, ir[21:10]};
         2'd1: v = {{19{ir[31]}}, ir[31:27], ir[16:10], 1'b0};
         2'd2: v = {ir[26:7], 12'h000};
         default: v = ir;
      endcase
      return v;
   endfunction

   function automatic logic [31:0] m_alu(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
      logic [31:0] off;
      off = {{6{b[31]}}, b[31:7], 1'b0};
      case (op)
         3'd0: return a + b;
         3'd1: return a - b;
         3'd2: return a;
         3'd3: return a & b;
         3'd4: return a | b;
         3'd5: return a ^ b;
         3'd6: return a + 32'd4;
         default: return a + off;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one cycle: drive at negedge, check combinational outputs, advance the model at posedge
   task automatic step(input logic [2:0] rs, input bit rwr, input bit ren,
                       input bit la, input bit lb, input bit lma, input bit lir,
                       input logic [2:0] aop, input bit aen,
                       input logic [1:0] isel, input bit ien,
                       input bit men, input bit mwr, input logic [31:0] rdat,
                       input bit mbusy, input string tag);
      logic [31:0] exp;
      int          ix;
      string       t;
      reg_sel = rs; reg_wr = rwr; reg_en = ren; ld_a = la; ld_b = lb; ld_ma = lma;
      ld_ir = lir; alu_op = aop; alu_en = aen; imm_sel = isel; imm_en = ien;
      mem_en = men; mem_wr = mwr; mem_rdata = rdat; mem_busy = mbusy;
      #1;
      ix  = m_idx(rs, m_ir);
      exp = '0;
      t   = "R2";
      if (ren)          begin exp |= (ix == 0) ? 32'h0 : m_reg[ix]; t = "R5"; end
      if (men && !mwr)  begin exp |= rdat; t = "R10"; end
      if (aen)          begin exp |= m_alu(aop, m_a, m_b); t = "R6"; end
      if (ien)          begin exp |= m_imm(isel, m_ir); t = "R7"; end
      if (tag != "") t = tag;
      chk(t, mem_wdata, exp);
      chk("R9 opcode", {25'h0, opcode}, {25'h0, m_ir[6:0]});
      chk("R8 br_eq", {31'h0, br_eq}, {31'h0, (m_a == m_b)});
      chk("R3 mem_addr", mem_addr, m_ma);
      chk("R10 mem_req", {31'h0, mem_req}, {31'h0, men});
      chk("R10 mem_we", {31'h0, mem_we}, {31'h0, men & mwr});
      chk("R10 busy", {31'h0, busy}, {31'h0, mbusy});
      @(posedge clk);
      if (la)  m_a  = exp;
      if (lb)  m_b  = exp;
      if (lma) m_ma = exp;
      if (rwr && ix != 0) m_reg[ix] = exp;
      if (lir) m_ir = exp;
      @(negedge clk);
   endtask

   task automatic idle(input string tag);
      step(3'd0, 0, 0, 0, 0, 0, 0, 3'd0, 0, 2'd0, 0, 0, 0, 32'h0, 0, tag);
   endtask

   // source helpers
   task automatic rd_reg(input logic [2:0] rs, input string tag);
      step(rs, 0, 1, 0, 0, 0, 0, 3'd0, 0, 2'd0, 0, 0, 0, 32'h0, 0, tag);
   endtask

   task automatic fetch_ir(input logic [31:0] w);
      step(3'd0, 0, 0, 0, 0, 0, 1, 3'd0, 0, 2'd0, 0, 1, 0, w, 1, "R10");
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < 33; i++) m_reg[i] = '0;
      m_reg[32] = 32'h200;
      m_a = '0; m_b = '0; m_ma = '0; m_ir = '0;

      repeat (3) @(negedge clk);
      // R1: state during reset
      #1;
      chk("R1 mem_addr in reset", mem_addr, 32'h0);
      chk("R1 opcode in reset", {25'h0, opcode}, 32'h0);
      chk("R1 br_eq in reset", {31'h0, br_eq}, 32'h1);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: PC and link after reset
      rd_reg(3'd3, "R1 pc reset");
      rd_reg(3'd4, "R1 link reset");
      step(3'd0, 0, 0, 0, 0, 0, 0, 3'd2, 1, 2'd0, 0, 0, 0, 32'h0, 0, "R1 A reset");

      // R2: no source gives zero
      idle("R2 idle bus");

      // rd=5 rs1=3 rs2=7, opcode 0x33
      fetch_ir(32'h28CE_A5B3);
      // R7 immediate forms written into R4-selected entries
      step(3'd2, 1, 0, 0, 0, 0, 0, 3'd0, 0, 2'd3, 1, 0, 0, 32'h0, 0, "R7 imm ir");
      step(3'd0, 1, 0, 0, 0, 0, 0, 3'd0, 0, 2'd0, 1, 0, 0, 32'h0, 0, "R7 imm i");
      step(3'd1, 1, 0, 0, 0, 0, 0, 3'd0, 0, 2'd1, 1, 0, 0, 32'h0, 0, "R7 imm br");
      step(3'd3, 1, 0, 0, 0, 0, 0, 3'd0, 0, 2'd2, 1, 0, 0, 32'h0, 0, "R7 imm up");
      step(3'd4, 1, 0, 0, 0, 0, 0, 3'd6, 1, 2'd0, 0, 0, 0, 32'h0, 0, "R6 inc4 to link");
      // R4: read back through each selector code
      for (int s = 0; s < 5; s++) rd_reg(3'(s), "R4 select readback");

      // R3/R6: load A from rd, B from rs2, then every ALU op
      step(3'd2, 0, 1, 1, 0, 0, 0, 3'd0, 0, 2'd0, 0, 0, 0, 32'h0, 0, "R3 load A");
      step(3'd1, 0, 1, 0, 1, 0, 0, 3'd0, 0, 2'd0, 0, 0, 0, 32'h0, 0, "R3 load B");
      for (int op = 0; op < 8; op++)
         step(3'd0, 0, 0, 0, 0, 0, 0, 3'(op), 1, 2'd0, 0, 0, 0, 32'h0, 0, "R6 alu op");
      step(3'd0, 0, 0, 0, 0, 1, 0, 3'd0, 1, 2'd0, 0, 0, 0, 32'h0, 0, "R3 load MA");
      idle("R3 MA visible");
      // R8: equal operands
      step(3'd2, 0, 1, 0, 1, 0, 0, 3'd0, 0, 2'd0, 0, 0, 0, 32'h0, 0, "R8 B equals A");
      idle("R8 equal check");
      // R10: write cycle does not drive the bus from memory
      step(3'd2, 0, 1, 0, 0, 0, 0, 3'd0, 0, 2'd0, 0, 1, 1, 32'hDEAD_BEEF, 1, "R10 write");

      // R5: rd field zero, write dropped, read stays zero
      fetch_ir(32'h0000_0013);
      step(3'd2, 1, 0, 0, 0, 0, 0, 3'd0, 0, 2'd3, 1, 0, 0, 32'h0, 0, "R5 write x0");
      rd_reg(3'd2, "R5 x0 reads zero");

      // random traffic
      for (int n = 0; n < 4000; n++) begin
         int drv = $urandom_range(0, 4);
         bit wr_mem = (drv != 2) && ($urandom_range(0, 3) == 0);
         step(3'($urandom_range(0, 4)), ($urandom_range(0, 3) == 0), drv == 1,
              ($urandom_range(0, 2) == 0), ($urandom_range(0, 2) == 0),
              ($urandom_range(0, 2) == 0), ($urandom_range(0, 4) == 0),
              3'($urandom_range(0, 7)), drv == 3, 2'($urandom_range(0, 3)), drv == 4,
              (drv == 2) || wr_mem, wr_mem, $urandom(), $urandom_range(0, 1) == 1, "");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule